// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block paces a 12-bit converter that has a parallel output bus. An internal sample timer requests a conversion at a fixed, run-time programmable interval. For each accepted request the block pulls the start line low to put the converter's front-end into hold. After a programmable settling time it releases the line, and the rising edge starts the conversion. The block then follows the converter's active-low busy line through a synchronizer. When busy returns high it reads the result and delivers it as a one-cycle valid pulse, with the data held until the next sample.

There are two read styles. In strobed mode the block lowers chip-select and read together for a programmed number of cycles and captures the bus on the last of them. In tied mode both lines stay low, and the bus is captured on the first cycle the synchronized busy line is seen high. In bipolar mode the converter's offset-binary code is recoded to two's complement on the way out. Any request that would start a conversion while one is running, or while busy is still low, is dropped and flagged. A timeout reports a converter that never answers. After every sample or timeout the block waits out a programmable acquisition gap before it accepts the next start.

All interval settings are counts of system clock cycles and must be at least 1.

Top module: `adc_seq`

## Requirements
- R1: An accepted request drives `cnv_start_n` low for exactly `cfg_hold` cycles, then high again; the rising edge is the conversion start.
- R2: While `cfg_en` is high, the timer issues one request every `cfg_period` cycles. While `cfg_en` is low it issues none and restarts its count.
- R3: A request that arrives while a sequence is in progress, or while the synchronized busy line is low, is dropped. It produces a one-cycle `err_overrun` pulse and no falling edge on `cnv_start_n`.
- R4: In strobed mode (`cfg_tied`=0), `cnv_cs_n` and `cnv_rd_n` go low together only after the synchronized busy line has been seen high. They stay low for `cfg_rdw` cycles and are high at all other times.
- R5: Each completed conversion gives exactly one one-cycle `smp_valid` pulse. `smp_data` changes only with that pulse and holds its value otherwise.
- R6: With `cfg_bipolar`=1, bit 11 of the captured code is inverted (0x800→0x000, 0x000→0x800, 0xFFF→0x7FF, 0x7FF→0xFFF). With `cfg_bipolar`=0, the code passes unchanged.
- R7: If busy does not fall within `TMO_CYC` cycles after the start edge, or does not rise within `TMO_CYC` cycles after falling, a one-cycle `err_timeout` pulse is raised. No sample is delivered in that case, and the sequence continues with the acquisition gap.
- R8: After a capture or a timeout, no new start is accepted for `cfg_gap` cycles.
- R9: In tied mode (`cfg_tied`=1), `cnv_cs_n` and `cnv_rd_n` stay low. The bus is captured on the first cycle the synchronized busy line is high, with no read phase.
- R10: The busy input passes through a two-flop synchronizer, so the block reacts to a busy edge two clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Enables the sample timer |
| cfg_bipolar | input | 1 | Recode output to two's complement |
| cfg_tied | input | 1 | Tied-low read mode |
| cfg_period | input | 16 | Sample interval in cycles |
| cfg_hold | input | 16 | Start-line low width in cycles |
| cfg_gap | input | 16 | Acquisition gap in cycles |
| cfg_rdw | input | 16 | Read strobe width in cycles |
| cnv_start_n | output | 1 | Conversion start line to converter |
| cnv_busy_n | input | 1 | Converter busy line, low while converting |
| cnv_cs_n | output | 1 | Converter chip-select, active low |
| cnv_rd_n | output | 1 | Converter read strobe, active low |
| cnv_data | input | 12 | Converter parallel data bus |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_data | output | 12 | Sample value, held between strobes |
| err_overrun | output | 1 | Dropped-request pulse |
| err_timeout | output | 1 | Converter timeout pulse |

## Verification
A timer request can land in the same cycle as the capture, as the end of the acquisition gap, or as a timeout. The request must then be judged against the state the sequencer had before that edge. The bench forces these collisions by running short sample periods, which overrun every conversion, and by stalling the converter stub before and after busy falls. A cycle-accurate behavioural model in the bench predicts every output on every clock. Any wrong choice between start and overrun on a collision cycle therefore shows up as a mismatch on `cnv_start_n` or `err_overrun`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_WFALL, S_WRISE, S_READ, S_ACQ
  } seq_st_e;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (tcnt == period - ONE);
      tcnt <= (tcnt >= period - ONE) ? '0 : tcnt + ONE;
    end
  end
endmodule

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/adc_seq_recode.sv
module adc_seq_recode #(
  parameter int DATA_W = 12
) (
  input  logic              bipolar,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == DATA_W - 1) begin : g_msb
        assign dout[i] = din[i] ^ bipolar;
      end else begin : g_low
        assign dout[i] = din[i];
      end
    end
  endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             busy_s,
  input  logic             cfg_tied,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic [CNT_W-1:0] cfg_gap,
  input  logic [CNT_W-1:0] cfg_rdw,
  output logic             start_n,
  output logic             cs_n,
  output logic             rd_n,
  output logic             cap,
  output logic             err_ovr,
  output logic             err_tmo
);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tmo;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + ONE;
    cap   = 1'b0;
    tmo   = 1'b0;
    case (st_q)
      S_IDLE: begin
        cnt_d = '0;
        if (tick && busy_s) st_d = S_HOLD;
      end
      S_HOLD:
        if (cnt_q == cfg_hold - ONE) begin
          st_d = S_WFALL; cnt_d = '0;
        end
      S_WFALL:
        if (!busy_s) begin
          st_d = S_WRISE; cnt_d = '0;
        end else if (cnt_q == TMO_LAST) begin
          tmo = 1'b1; st_d = S_ACQ; cnt_d = '0;
        end
      S_WRISE:
        if (busy_s) begin
          cnt_d = '0;
          if (cfg_tied) begin
            cap = 1'b1; st_d = S_ACQ;
          end else begin
            st_d = S_READ;
          end
        end else if (cnt_q == TMO_LAST) begin
          tmo = 1'b1; st_d = S_ACQ; cnt_d = '0;
        end
      S_READ:
        if (cnt_q == cfg_rdw - ONE) begin
          cap = 1'b1; st_d = S_ACQ; cnt_d = '0;
        end
      S_ACQ:
        if (cnt_q == cfg_gap - ONE) begin
          st_d = S_IDLE; cnt_d = '0;
        end
      default: begin
        st_d = S_IDLE; cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      start_n <= 1'b1;
      cs_n    <= 1'b1;
      rd_n    <= 1'b1;
      err_ovr <= 1'b0;
      err_tmo <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      start_n <= (st_d != S_HOLD);
      cs_n    <= !(cfg_tied || st_d == S_READ);
      rd_n    <= !(cfg_tied || st_d == S_READ);
      err_ovr <= tick && (st_q != S_IDLE || !busy_s);
      err_tmo <= tmo;
    end
  end

  AST_START_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    $fell(start_n) |-> $past(busy_s)); // R3
  AST_OVERRUN_NO_START: assert property (@(posedge clk) disable iff (rst)
    err_ovr |-> !$fell(start_n)); // R3
  AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(busy_s)); // R4
  AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    cs_n == rd_n); // R4
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DATA_W  = 12,
  parameter int CNT_W   = 16,
  parameter int TMO_CYC = 64,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_bipolar,
  input  logic              cfg_tied,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [CNT_W-1:0]  cfg_gap,
  input  logic [CNT_W-1:0]  cfg_rdw,
  output logic              cnv_start_n,
  input  logic              cnv_busy_n,
  output logic              cnv_cs_n,
  output logic              cnv_rd_n,
  input  logic [DATA_W-1:0] cnv_data,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              err_overrun,
  output logic              err_timeout
);
  logic              tick, busy_s, cap;
  logic [DATA_W-1:0] coded;

  adc_seq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst(rst), .en(cfg_en), .period(cfg_period), .tick(tick));

  adc_seq_sync #(.STAGES(SYNC_N)) i_sync (
    .clk(clk), .rst(rst), .din(cnv_busy_n), .dout(busy_s));

  adc_seq_ctrl #(.CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) i_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .busy_s(busy_s), .cfg_tied(cfg_tied),
    .cfg_hold(cfg_hold), .cfg_gap(cfg_gap), .cfg_rdw(cfg_rdw),
    .start_n(cnv_start_n), .cs_n(cnv_cs_n), .rd_n(cnv_rd_n), .cap(cap),
    .err_ovr(err_overrun), .err_tmo(err_timeout));

  adc_seq_recode #(.DATA_W(DATA_W)) i_recode (
    .bipolar(cfg_bipolar), .din(cnv_data), .dout(coded));

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      smp_valid <= cap;
      if (cap) smp_data <= coded;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid); // R5
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |-> $stable(smp_data)); // R5
  AST_TIMEOUT_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    err_timeout |-> !smp_valid); // R7
endmodule

// File: tb/test_adc_seq.sv
module test_adc_seq;
  localparam int TMO  = 64;
  localparam int CONV = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0, cfg_bipolar = 1'b0, cfg_tied = 1'b0;
  logic [15:0] cfg_period = 16'd40, cfg_hold = 16'd3, cfg_gap = 16'd4, cfg_rdw = 16'd2;
  logic        cnv_start_n, cnv_cs_n, cnv_rd_n, smp_valid, err_overrun, err_timeout;
  logic        cnv_busy_n = 1'b1;
  logic [11:0] cnv_data = '0, smp_data;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  adc_seq i_adc_seq (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bipolar(cfg_bipolar),
    .cfg_tied(cfg_tied), .cfg_period(cfg_period), .cfg_hold(cfg_hold),
    .cfg_gap(cfg_gap), .cfg_rdw(cfg_rdw), .cnv_start_n(cnv_start_n),
    .cnv_busy_n(cnv_busy_n), .cnv_cs_n(cnv_cs_n), .cnv_rd_n(cnv_rd_n),
    .cnv_data(cnv_data), .smp_valid(smp_valid), .smp_data(smp_data),
    .err_overrun(err_overrun), .err_timeout(err_timeout));

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- converter stub ----------------
  logic [11:0] code_cur = '0;
  int          seq_idx = 0, conv_left = 0;
  logic        prev_start = 1'b1, dead = 1'b0, stuck = 1'b0;
  logic [11:0] corner [4] = '{12'h000, 12'h7FF, 12'h800, 12'hFFF};

  function automatic logic [11:0] next_code(input int i);
    if (i < 4) return corner[i];
    return 12'((i * 1237 + 291) % 4096);
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      cnv_busy_n = 1'b1; prev_start = 1'b1; conv_left = 0;
    end else begin
      if (prev_start && !cnv_start_n && !cnv_busy_n)
        check("R3 start while busy", 1, 0);
      if (!prev_start && cnv_start_n && cnv_busy_n && !dead) begin
        cnv_busy_n = 1'b0; conv_left = CONV;
      end else if (!cnv_busy_n && !stuck) begin
        conv_left--;
        if (conv_left <= 0) begin
          cnv_busy_n = 1'b1; code_cur = next_code(seq_idx); seq_idx++;
        end
      end
      prev_start = cnv_start_n;
    end
    cnv_data = (cnv_busy_n && !cnv_cs_n && !cnv_rd_n) ? code_cur : 12'h000;
  end

  // ---------------- reference model ----------------
  int   phase, left, w, k;
  logic m_tick, ms1, ms2;
  logic e_start, e_cs, e_valid, e_ovr, e_tmo;
  logic [11:0] e_data;
  int   n_valid = 0, n_ovr = 0, n_tmo = 0;

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; left = 0; w = 0; k = 0; m_tick = 0; ms1 = 1; ms2 = 1;
      e_start = 1; e_cs = 1; e_valid = 0; e_data = '0; e_ovr = 0; e_tmo = 0;
    end else begin
      automatic logic bo = ms2;
      automatic logic to = m_tick;
      automatic int   po = phase;
      if (cfg_en) begin
        m_tick = ((k % int'(cfg_period)) == int'(cfg_period) - 1); k++;
      end else begin
        m_tick = 0; k = 0;
      end
      e_valid = 0; e_tmo = 0;
      e_ovr = to && (po != 0 || !bo);
      case (po)
        0: if (to && bo) begin phase = 1; left = cfg_hold; end
        1: begin left--; if (left == 0) begin phase = 2; w = 0; end end
        2: if (!bo) begin phase = 3; w = 0; end
           else begin w++; if (w == TMO) begin e_tmo = 1; phase = 5; left = cfg_gap; end end
        3: if (bo) begin
             if (cfg_tied) begin
               e_valid = 1; e_data = cfg_bipolar ? code_cur ^ 12'h800 : code_cur;
               phase = 5; left = cfg_gap;
             end else begin phase = 4; left = cfg_rdw; end
           end else begin w++; if (w == TMO) begin e_tmo = 1; phase = 5; left = cfg_gap; end end
        4: begin left--; if (left == 0) begin
             e_valid = 1; e_data = cfg_bipolar ? code_cur ^ 12'h800 : code_cur;
             phase = 5; left = cfg_gap; end end
        5: begin left--; if (left == 0) phase = 0; end
        default: phase = 0;
      endcase
      ms2 = ms1; ms1 = cnv_busy_n;
      e_start = (phase != 1);
      e_cs = !(cfg_tied || phase == 4);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check("R1 R2 R8 start line", cnv_start_n, e_start);
      check(cfg_tied ? "R9 cs_n" : "R4 R10 cs_n", cnv_cs_n, e_cs);
      check(cfg_tied ? "R9 rd_n" : "R4 rd_n", cnv_rd_n, e_cs);
      check("R5 valid", smp_valid, e_valid);
      check("R5 R6 data", smp_data, e_data);
      check("R3 overrun", err_overrun, e_ovr);
      check("R7 timeout", err_timeout, e_tmo);
      if (smp_valid) n_valid++;
      if (err_overrun) n_ovr++;
      if (err_timeout) n_tmo++;
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pause();
    cfg_en = 1'b0; run(200);
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1 reset start_n", cnv_start_n, 1);
    check("R4 reset cs_n", cnv_cs_n, 1);
    check("R5 reset valid", smp_valid, 0);
    check("R7 reset flags", {err_overrun, err_timeout}, 0);

    // strobed read, unipolar: corner codes pass unchanged
    cfg_en = 1'b1; run(400);
    check("R5 samples delivered", int'(n_valid > 5), 1);
    pause();

    // bipolar, tied mode, shortest hold
    cfg_bipolar = 1'b1; cfg_tied = 1'b1; cfg_hold = 16'd1; n_valid = 0;
    cfg_en = 1'b1; run(400);
    check("R9 R6 tied samples", int'(n_valid > 5), 1);
    pause();

    // overrun: period shorter than a conversion, collisions on gap end
    cfg_tied = 1'b0; cfg_period = 16'd12; cfg_gap = 16'd1; cfg_rdw = 16'd1;
    cfg_en = 1'b1; run(400);
    check("R3 overruns flagged", int'(n_ovr > 0), 1);
    pause();
    cfg_period = 16'd23; cfg_gap = 16'd2;
    cfg_en = 1'b1; run(400);
    pause();

    // converter never answers
    cfg_period = 16'd50; cfg_gap = 16'd4; cfg_rdw = 16'd3; dead = 1'b1;
    cfg_en = 1'b1; run(300);
    check("R7 timeout no fall", int'(n_tmo > 0), 1);
    pause(); dead = 1'b0;

    // converter stalls with busy low
    n_tmo = 0; stuck = 1'b1;
    cfg_en = 1'b1; run(300);
    check("R7 timeout no rise", int'(n_tmo > 0), 1);
    stuck = 1'b0; run(300);
    pause();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule